// File: doc/BRIEF.md
# Q15 Fractional Multiplier with Rounding

This block multiplies two signed 16-bit fractional operands held in Q15 form. Each operand has one sign bit and fifteen fraction bits, so it covers -1.0 up to 1 - 2^-15 in steps of 2^-15. The block returns a product in the same format.

The exact signed product is a 32-bit Q30 value whose two top bits are both copies of the sign. The block drops the redundant copy by aligning the product one place to the left, and keeps the upper sixteen bits. In nearest mode it adds half an output LSB before discarding the low bits, which gives round-half-up to nearest. In truncate mode the low bits are dropped, which rounds toward minus infinity.

The only product that cannot be represented is (-1.0) x (-1.0). That product, and any sum that rounding would carry past the largest positive code, saturates to 0x7FFF and raises an overflow flag for that result. Operands and the mode bit are taken on a valid/ready transfer. The result appears in a register one cycle later.

Top module: `q15_mul_round`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_data`, `out_ovf` and `in_ready` are all 0. `in_ready` rises on the first clock edge after reset is released.
- R2: A transfer (`in_valid` and `in_ready` both high at a rising edge) produces `out_valid` high after exactly that edge and no other. Back-to-back transfers give back-to-back results. A cycle without a transfer gives `out_valid` low after the next edge.
- R3: With `in_mode` = 0 (truncate), `out_data` equals floor(A*B / 2^15), where A and B are the operands read as two's complement integers.
- R4: With `in_mode` = 1 (nearest), `out_data` equals floor(A*B / 2^15 + 1/2). The half-LSB weight is bit 14 of the 32-bit product.
- R5: For operands 0x8000 and 0x8000 in either mode, `out_data` is 0x7FFF and `out_ovf` is 1.
- R6: Whenever the aligned and rounded value exceeds 32767, the result is 0x7FFF and `out_ovf` is 1. For every other result, `out_ovf` is 0.
- R7: The mode is sampled with each transfer. Consecutive transfers may use different modes, and each result follows the mode of its own transfer.
- R8: In a cycle without a transfer, `out_data` and `out_ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are presented |
| in_ready | output | 1 | Block accepts a transfer this cycle |
| in_a | input | 16 | First Q15 operand |
| in_b | input | 16 | Second Q15 operand |
| in_mode | input | 1 | 0 = truncate, 1 = round to nearest |
| out_valid | output | 1 | A result is present this cycle |
| out_data | output | 16 | Q15 product |
| out_ovf | output | 1 | Result was saturated |

## Verification
The assertions check the cycle-level properties on every cycle:
- the one-cycle latency between a transfer and `out_valid`;
- the quiet outputs during reset;
- the holding of the result when no transfer occurs;
- the saturated code that must accompany the overflow flag;
- the fixed response to the (-1.0) x (-1.0) pair.

The arithmetic itself can only be shown by the bench's scenarios. It streams tens of thousands of operand pairs across the whole signed range, alternates the mode between neighbouring transfers, and compares each result with floor and round-half-up values computed on full-width integers. The negative-one-LSB product, zero operands and the extreme operand pairs are driven as separate cases.

// File: rtl/q15_pkg.sv
package q15_pkg;
  typedef enum logic {
    RND_TRUNC = 1'b0,
    RND_NEAR  = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/q15_product.sv
module q15_product #(
  parameter int W = 16,
  localparam int FRAC = W - 1,
  localparam int PW = 2 * W,
  localparam int HI_W = PW - FRAC + 1
) (
  input  logic signed [W-1:0]    op_a,
  input  logic signed [W-1:0]    op_b,
  output logic        [HI_W-1:0] prod_hi
);
  logic signed [PW-1:0] prod_full;
  logic                 unused_low;

  always_comb begin
    prod_full = op_a * op_b;
  end

  // keep the integer part plus the half-LSB weight; lower bits never matter
  assign prod_hi    = prod_full[PW-1:FRAC-1];
  assign unused_low = ^prod_full[FRAC-2:0];
endmodule

// File: rtl/q15_align_round.sv
module q15_align_round
  import q15_pkg::*;
#(
  parameter int W = 16,
  localparam int HI_W = W + 2
) (
  input  logic [HI_W-1:0] prod_hi,
  input  rnd_mode_e       mode,
  output logic [W-1:0]    res,
  output logic            ovf
);
  localparam logic signed [W+1:0] MAX_V = (W+2)'((1 << (W - 1)) - 1);
  localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};

  logic signed [W:0]   kept;
  logic                half;
  logic                inc;
  logic signed [W+1:0] sum;

  always_comb begin
    kept = prod_hi[HI_W-1:1];
    half = prod_hi[0];
    inc  = (mode == RND_NEAR) && half;
    sum  = {kept[W], kept} + {{(W+1){1'b0}}, inc};
    ovf  = sum > MAX_V;
    res  = ovf ? MAX_CODE : sum[W-1:0];
  end
endmodule

// File: rtl/q15_mul_round.sv
module q15_mul_round
  import q15_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_mode,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_ovf
);
  localparam int HI_W = W + 2;
  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};

  logic            ready_q;
  logic            vld_q, vld_n;
  logic [W-1:0]    data_q, data_n;
  logic            ovf_q, ovf_n;
  logic            accept;
  logic [HI_W-1:0] prod_hi;
  logic [W-1:0]    res;
  logic            res_ovf;
  rnd_mode_e       mode;

  assign mode = rnd_mode_e'(in_mode);

  q15_product #(.W(W)) u_prod (
    .op_a    (in_a),
    .op_b    (in_b),
    .prod_hi (prod_hi)
  );

  q15_align_round #(.W(W)) u_align (
    .prod_hi (prod_hi),
    .mode    (mode),
    .res     (res),
    .ovf     (res_ovf)
  );

  assign accept = in_valid && ready_q;

  always_comb begin
    vld_n  = accept;
    data_n = data_q;
    ovf_n  = ovf_q;
    if (accept) begin
      data_n = res;
      ovf_n  = res_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
      data_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= vld_n;
      data_q  <= data_n;
      ovf_q   <= ovf_n;
    end
  end

  assign in_ready  = ready_q;
  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_ovf   = ovf_q;

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!out_valid && !out_ovf && !in_ready && out_data == '0)
        else $error("reset outputs not quiet");
    end
  end

  // R2: one-cycle latency from transfer to out_valid
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  // R5: (-1.0) x (-1.0) saturates
  p_minmin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a == MIN_CODE && in_b == MIN_CODE)
      |=> (out_data == MAX_CODE && out_ovf));

  // R6: overflow flag always comes with the saturated code
  p_ovf_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_data == MAX_CODE);

  // R8: result held without a transfer
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(out_data) && $stable(out_ovf)));
endmodule

// File: tb/q15_mul_round_test.sv
`timescale 1ns/1ps
module q15_mul_round_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_a;
  logic [15:0] in_b;
  logic        in_mode;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ovf;

  int checks;
  int errors;
  bit finished;

  logic        pend;
  logic [15:0] exp_data;
  logic        exp_ovf;
  logic        exp_mode;

  q15_mul_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                input logic m, output logic [15:0] d,
                                output logic o);
    longint p;
    longint q;
    p = longint'($signed(a)) * longint'($signed(b));
    q = p >>> 15;
    if (m) q = q + ((p >>> 14) & 64'sd1);
    o = (q > 32767);
    if (o) q = 32767;
    d = q[15:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // check last cycle's outcome at this negedge, then drive the next cycle
  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic m);
    @(negedge clk);
    chk("R2 out_valid", {31'd0, out_valid}, {31'd0, pend});
    if (pend) begin
      chk(exp_mode ? "R4/R7 nearest data" : "R3/R7 truncate data", {16'd0, out_data}, {16'd0, exp_data});
      chk("R6 overflow flag", {31'd0, out_ovf}, {31'd0, exp_ovf});
    end else begin
      chk("R8 held data", {16'd0, out_data}, {16'd0, exp_data});
      chk("R8 held flag", {31'd0, out_ovf}, {31'd0, exp_ovf});
    end
    in_valid = v;
    in_a     = a;
    in_b     = b;
    in_mode  = m;
    pend     = v;
    if (v) begin
      model(a, b, m, exp_data, exp_ovf);
      exp_mode = m;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    in_valid = 1'b0; in_a = '0; in_b = '0; in_mode = 1'b0;
    pend = 1'b0; exp_data = '0; exp_ovf = 1'b0; exp_mode = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 out_data", {16'd0, out_data}, 32'd0);
    chk("R1 out_ovf", {31'd0, out_ovf}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after release", {31'd0, in_ready}, 32'd1);

    // R5 and R6: the unrepresentable product in both modes
    step(1'b1, 16'h8000, 16'h8000, 1'b0);
    step(1'b1, 16'h8000, 16'h8000, 1'b1);
    // extreme and small cases
    step(1'b1, 16'h8000, 16'h7FFF, 1'b0);
    step(1'b1, 16'h8000, 16'h7FFF, 1'b1);
    step(1'b1, 16'h7FFF, 16'h7FFF, 1'b1);
    step(1'b1, 16'hFFFF, 16'h0001, 1'b0);   // R3: -1 LSB^2 floors to 0xFFFF
    step(1'b1, 16'hFFFF, 16'h0001, 1'b1);   // R4: rounds to 0
    step(1'b1, 16'h0000, 16'h8000, 1'b1);
    step(1'b1, 16'h4000, 16'h0001, 1'b1);   // R4: exact half rounds up
    step(1'b1, 16'h4000, 16'h0001, 1'b0);   // R3/R7: same operands truncated
    // R8: idle cycles hold the last result, then R2 gap
    step(1'b0, 16'h1234, 16'h5678, 1'b1);
    step(1'b0, 16'h8000, 16'h8000, 1'b1);
    step(1'b1, 16'h8000, 16'h8000, 1'b0);
    step(1'b0, 16'h0000, 16'h0000, 1'b0);   // R8: overflow flag held
    step(1'b0, 16'h0000, 16'h0000, 1'b0);

    // streaming sweep across the signed range, mode alternating per transfer
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 256; j++) begin
        step(1'b1, 16'(i * 517 + 3), 16'(j * 257 + 13), 1'((i + j) & 1));
      end
      step(1'b0, 16'h0, 16'h0, 1'b0);
    end
    step(1'b0, 16'h0, 16'h0, 1'b0);
    finish_run();
  end
endmodule